// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a synchronous front end for an asynchronous static memory of 2^WORD_AW words of 32 bits. The memory is split into four 8-bit byte lanes. Each lane has its own active-low chip select and write enable. All lanes share one active-low output enable and one word address bus. A user issues a single transfer by raising `req` with an address, write data, a direction flag and a width mode. The controller then walks a fixed sequence of timed phases on the memory pins and pulses `ack` when the transfer is finished.

The width mode lets the same 32-bit memory serve as a 16-bit or an 8-bit memory with two or four times as many locations. The low user address bits pick the lanes to enable. Narrow write data is placed on the chosen lanes. Narrow read data is shifted down to the low bits of `rdata`.

Phase lengths are whole clock counts set by parameters, so a slower or faster memory grade only changes the parameter values. The shared data bus is split into `dq_out`, `dq_oe` and `dq_in`, so a pad cell outside the block can form the tristate.

The state machine has six states:
- `ST_IDLE`: waits for a request.
- `ST_WR_SETUP`: address and chip selects are out, write enable is still high.
- `ST_WR_PULSE`: write enable is low.
- `ST_WR_RECOV`: selects and write enable are released while data is held.
- `ST_RD_ACCESS`: chip selects and output enable are low.
- `ST_RD_TURN`: everything is released before the bus may be driven again.

The transitions are:
- IDLE to WR_SETUP on a write request, and IDLE to RD_ACCESS on a read request.
- WR_SETUP to WR_PULSE to WR_RECOV to IDLE, each move taken when the phase count expires.
- RD_ACCESS to RD_TURN to IDLE, each move taken when the phase count expires.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and in idle, all of `mem_cs_n`, all of `mem_we_n` and `mem_oe_n` are high, while `dq_oe` and `ack` are low.
- R2: Mode 2'b00 (32-bit) enables all four lanes and uses word `addr[WORD_AW-1:0]`. Write data is `wdata[31:0]` and read data is returned unshifted.
- R3: Mode 2'b01 (16-bit) uses word `addr[WORD_AW:1]`. `addr[0]`=0 enables lanes 0 and 1 (bits 15:0) and `addr[0]`=1 enables lanes 2 and 3 (bits 31:16). `wdata[15:0]` goes onto the enabled lanes, and read data appears in `rdata[15:0]` with `rdata[31:16]` zero.
- R4: Mode 2'b10 (8-bit) uses word `addr[WORD_AW+1:2]`, and `addr[1:0]` enables lane n (bits 8n+7:8n). `wdata[7:0]` goes onto that lane, and read data appears in `rdata[7:0]` with the rest zero.
- R5: Mode 2'b11 behaves exactly as mode 2'b00.
- R6: A write shows three phases in order: WR_SETUP clocks with selected CS low and WE high, then WR_PULSE clocks with selected CS and WE low, then WR_RECOV clocks with all CS and WE high. OE stays high throughout, and `mem_addr` holds the word while any CS is low.
- R7: `dq_oe` stays low for the first WR_HIZ clocks of the pulse phase. It is high for the rest of the pulse and for the whole recovery. While it is high, `dq_out` carries the write data on the selected lanes and zero on all other lanes.
- R8: A read holds the selected CS and OE low for RD_ACCESS clocks with WE high. `dq_in` is captured on the clock edge that ends that phase.
- R9: After a read, CS and OE are high and `dq_oe` is low for RD_TURN clocks before `ack`. `dq_oe` is never high while OE is low.
- R10: `ack` is high for exactly one clock, in the first idle cycle after a transfer. `rdata` keeps its value until the next read captures.
- R11: A request is taken only in idle. A request raised during a transfer causes no pin activity and no extra transfer.
- R12: Lanes outside the selected set keep CS and WE high, so their memory bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, sampled in idle |
| wr | input | 1 | 1 = write, 0 = read |
| mode | input | 2 | Width mode: 00 x32, 01 x16, 10 x8, 11 as x32 |
| addr | input | WORD_AW+2 | User address in units of the chosen width |
| wdata | input | 32 | Write data, right-aligned for narrow modes |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read data, right-aligned, upper bits zero in narrow modes |
| mem_addr | output | WORD_AW | Memory word address |
| mem_cs_n | output | 4 | Per-lane chip select, active low |
| mem_we_n | output | 4 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| dq_out | output | 32 | Data toward the memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 32 | Data from the memory |

## Verification
The bench builds the block with a 6-bit word address, setup 2, pulse 4, WE-to-float wait 2, recovery 2, access 3 and turnaround 2. Every phase therefore spans several clocks, and the partial data-drive window inside the pulse becomes visible. The small memory lets the behavioural SRAM model cover the top word, which the highest user address in each width reaches. A write followed by a narrow readback, and a full-word readback of the same word, show whether untouched lanes survive.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        MODE_X32 = 2'b00,
        MODE_X16 = 2'b01,
        MODE_X8  = 2'b10,
        MODE_RSV = 2'b11
    } width_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS,
        ST_RD_TURN
    } ctrl_state_e;
endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
    import sram_lane_pkg::*;
#(
    parameter int WORD_AW = 17,
    parameter int LANE_W  = 8
) (
    input  width_mode_e               mode,
    input  logic [WORD_AW+1:0]        addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [WORD_AW-1:0]        word,
    output logic [LANES-1:0]          lane_en,
    output logic [LANES*LANE_W-1:0]   wlanes,
    output logic [1:0]                sel
);
    always_comb begin
        unique case (mode)
            MODE_X16: begin
                word = addr[WORD_AW:1];
                sel  = {addr[0], 1'b0};
            end
            MODE_X8: begin
                word = addr[WORD_AW+1:2];
                sel  = addr[1:0];
            end
            default: begin
                word = addr[WORD_AW-1:0];
                sel  = 2'b00;
            end
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic              en;
        logic [LANE_W-1:0] v;
        always_comb begin
            unique case (mode)
                MODE_X16: begin
                    en = ((k / 2) == int'(sel[1]));
                    v  = wdata[(k % 2)*LANE_W +: LANE_W];
                end
                MODE_X8: begin
                    en = (k == int'(sel));
                    v  = wdata[LANE_W-1:0];
                end
                default: begin
                    en = 1'b1;
                    v  = wdata[k*LANE_W +: LANE_W];
                end
            endcase
        end
        assign lane_en[k]                = en;
        assign wlanes[k*LANE_W +: LANE_W] = en ? v : '0;
    end
endmodule

// File: rtl/sram_rd_align.sv
module sram_rd_align
    import sram_lane_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  width_mode_e             mode,
    input  logic [1:0]              sel,
    input  logic [LANES*LANE_W-1:0] dq,
    output logic [LANES*LANE_W-1:0] rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] v;
        always_comb begin
            unique case (mode)
                MODE_X16: v = (k < 2) ? dq[(int'(sel[1])*2 + (k % 2))*LANE_W +: LANE_W] : '0;
                MODE_X8:  v = (k == 0) ? dq[int'(sel)*LANE_W +: LANE_W] : '0;
                default:  v = dq[k*LANE_W +: LANE_W];
            endcase
        end
        assign rdata[k*LANE_W +: LANE_W] = v;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int WORD_AW   = 17,
    parameter int LANE_W    = 8,
    parameter int WR_SETUP  = 1,
    parameter int WR_PULSE  = 3,
    parameter int WR_HIZ    = 1,
    parameter int WR_RECOV  = 1,
    parameter int RD_ACCESS = 2,
    parameter int RD_TURN   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic                      wr,
    input  logic [1:0]                mode,
    input  logic [WORD_AW+1:0]        addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic                      ack,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic [WORD_AW-1:0]        mem_addr,
    output logic [LANES-1:0]          mem_cs_n,
    output logic [LANES-1:0]          mem_we_n,
    output logic                      mem_oe_n,
    output logic [LANES*LANE_W-1:0]   dq_out,
    output logic                      dq_oe,
    input  logic [LANES*LANE_W-1:0]   dq_in
);
    localparam int DW     = LANES * LANE_W;
    localparam int MAX_A  = (WR_SETUP > WR_PULSE) ? WR_SETUP : WR_PULSE;
    localparam int MAX_B  = (WR_RECOV > RD_ACCESS) ? WR_RECOV : RD_ACCESS;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_PH = (MAX_C > RD_TURN) ? MAX_C : RD_TURN;
    localparam int CNT_W  = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;
    localparam int DRV_AT = WR_PULSE - WR_HIZ;

    ctrl_state_e           state, nxt;
    logic [CNT_W-1:0]      cnt;
    logic [WORD_AW-1:0]    word_d, word_q;
    logic [LANES-1:0]      en_d, en_q;
    logic [DW-1:0]         wl_d, wl_q, rd_aligned;
    logic [1:0]            sel_d, sel_q;
    width_mode_e           mode_q;
    logic                  ack_q;
    logic [DW-1:0]         rdata_q;

    sram_lane_map #(.WORD_AW(WORD_AW), .LANE_W(LANE_W)) i_map (
        .mode    (width_mode_e'(mode)),
        .addr    (addr),
        .wdata   (wdata),
        .word    (word_d),
        .lane_en (en_d),
        .wlanes  (wl_d),
        .sel     (sel_d)
    );

    sram_rd_align #(.LANE_W(LANE_W)) i_align (
        .mode  (mode_q),
        .sel   (sel_q),
        .dq    (dq_in),
        .rdata (rd_aligned)
    );

    function automatic logic [CNT_W-1:0] phase_len(ctrl_state_e s);
        case (s)
            ST_WR_SETUP:  return CNT_W'(WR_SETUP - 1);
            ST_WR_PULSE:  return CNT_W'(WR_PULSE - 1);
            ST_WR_RECOV:  return CNT_W'(WR_RECOV - 1);
            ST_RD_ACCESS: return CNT_W'(RD_ACCESS - 1);
            ST_RD_TURN:   return CNT_W'(RD_TURN - 1);
            default:      return '0;
        endcase
    endfunction

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (req) nxt = wr ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_WR_SETUP:  if (cnt == '0) nxt = ST_WR_PULSE;
            ST_WR_PULSE:  if (cnt == '0) nxt = ST_WR_RECOV;
            ST_WR_RECOV:  if (cnt == '0) nxt = ST_IDLE;
            ST_RD_ACCESS: if (cnt == '0) nxt = ST_RD_TURN;
            ST_RD_TURN:   if (cnt == '0) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            word_q  <= '0;
            en_q    <= '0;
            wl_q    <= '0;
            sel_q   <= '0;
            mode_q  <= MODE_X32;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= phase_len(nxt);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (state == ST_IDLE && req) begin
                word_q <= word_d;
                en_q   <= en_d;
                wl_q   <= wl_d;
                sel_q  <= sel_d;
                mode_q <= width_mode_e'(mode);
            end
            if (state == ST_RD_ACCESS && cnt == '0)
                rdata_q <= rd_aligned;
            ack_q <= (nxt == ST_IDLE) && (state != ST_IDLE);
        end
    end

    always_comb begin
        mem_cs_n = '1;
        mem_we_n = '1;
        mem_oe_n = 1'b1;
        dq_oe    = 1'b0;
        unique case (state)
            ST_WR_SETUP: mem_cs_n = ~en_q;
            ST_WR_PULSE: begin
                mem_cs_n = ~en_q;
                mem_we_n = ~en_q;
                dq_oe    = (cnt < CNT_W'(DRV_AT));
            end
            ST_WR_RECOV: dq_oe = 1'b1;
            ST_RD_ACCESS: begin
                mem_cs_n = ~en_q;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign mem_addr = word_q;
    assign dq_out   = wl_q;
    assign ack      = ack_q;
    assign rdata    = rdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int WORD_AW = 17
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         mem_cs_n,
    input logic [3:0]         mem_we_n,
    input logic               mem_oe_n,
    input logic               dq_oe,
    input logic               ack,
    input logic [WORD_AW-1:0] mem_addr
);
    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mem_we_n) & mem_cs_n) == 4'b0000); // R6
    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (~mem_cs_n) inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}); // R12
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> mem_oe_n); // R9
    AST_DRIVE_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> ($past(mem_we_n) != 4'hF)); // R7
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != 4'hF) |-> mem_oe_n); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != 4'hF && $past(mem_cs_n) != 4'hF) |-> $stable(mem_addr)); // R6
    AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R10
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.WORD_AW(WORD_AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .dq_oe    (dq_oe),
    .ack      (ack),
    .mem_addr (mem_addr)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
    localparam int WORD_AW = 6, LANE_W = 8;
    localparam int WS = 2, WP = 4, WH = 2, WRC = 2, RA = 3, RT = 2;
    localparam int UAW = WORD_AW + 2, DEPTH = 1 << WORD_AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, req = 1'b0, wr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [UAW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata, dq_out, dq_in;
    logic ack, mem_oe_n, dq_oe;
    logic [WORD_AW-1:0] mem_addr;
    logic [3:0] mem_cs_n, mem_we_n;

    sram_lane_ctrl #(.WORD_AW(WORD_AW), .LANE_W(LANE_W), .WR_SETUP(WS), .WR_PULSE(WP),
        .WR_HIZ(WH), .WR_RECOV(WRC), .RD_ACCESS(RA), .RD_TURN(RT)) i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .mode(mode), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    // Behavioural memory driven only by the pins
    logic [31:0] mem [DEPTH];
    logic [31:0] shadow [DEPTH];
    always_comb
        for (int l = 0; l < 4; l++)
            dq_in[l*8 +: 8] = (!mem_cs_n[l] && mem_we_n[l] && !mem_oe_n) ? mem[mem_addr][l*8 +: 8] : 8'hEE;
    always @(posedge clk)
        for (int l = 0; l < 4; l++)
            if (!mem_cs_n[l] && !mem_we_n[l] && dq_oe) mem[mem_addr][l*8 +: 8] <= dq_out[l*8 +: 8];

    typedef struct {
        logic [3:0] cs_n, we_n;
        logic oe_n, doe, ack, chk_rd;
        logic [WORD_AW-1:0] adr;
        logic [31:0] dout, rdat;
        string tg;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    logic [31:0] last_rd = '0;

    function automatic exp_t idle_e(string tg);
        exp_t e;
        e.cs_n = 4'hF; e.we_n = 4'hF; e.oe_n = 1'b1; e.doe = 1'b0; e.ack = 1'b0;
        e.chk_rd = 1'b0; e.adr = '0; e.dout = '0; e.rdat = '0; e.tg = tg;
        return e;
    endfunction

    task automatic chk(input bit ok, input string tg, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else e = idle_e(rst_n ? "R1/R11" : "R1");
        chk(mem_cs_n === e.cs_n, e.tg, "cs_n", 32'(mem_cs_n), 32'(e.cs_n));
        chk(mem_we_n === e.we_n, e.tg, "we_n", 32'(mem_we_n), 32'(e.we_n));
        chk(mem_oe_n === e.oe_n, e.tg, "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
        chk(dq_oe === e.doe, e.tg, "dq_oe", 32'(dq_oe), 32'(e.doe));
        chk(ack === e.ack, e.tg, "ack", 32'(ack), 32'(e.ack));
        if (e.cs_n != 4'hF) chk(mem_addr === e.adr, e.tg, "mem_addr", 32'(mem_addr), 32'(e.adr));
        if (e.doe) chk(dq_out === e.dout, e.tg, "dq_out", dq_out, e.dout);
        if (e.chk_rd) chk(rdata === e.rdat, e.tg, "rdata", rdata, e.rdat);
    end

    task automatic xfer(input bit w, input logic [1:0] md, input logic [UAW-1:0] a,
                        input logic [31:0] d, input bit glitch, input string mtag);
        int m;
        logic [WORD_AW-1:0] wd;
        logic [3:0] msk;
        logic [31:0] wl, bm, rd;
        exp_t e;
        m = (md == 2'b11) ? 0 : int'(md);
        case (m)
            1: begin wd = a[WORD_AW:1]; msk = a[0] ? 4'hC : 4'h3; wl = {2{d[15:0]}}; end
            2: begin wd = a[WORD_AW+1:2]; msk = 4'b0001 << a[1:0]; wl = {4{d[7:0]}}; end
            default: begin wd = a[WORD_AW-1:0]; msk = 4'hF; wl = d; end
        endcase
        bm = '0;
        for (int l = 0; l < 4; l++) if (msk[l]) bm[l*8 +: 8] = 8'hFF;
        wl = wl & bm;
        case (m)
            1: rd = a[0] ? {16'h0, shadow[wd][31:16]} : {16'h0, shadow[wd][15:0]};
            2: rd = {24'h0, shadow[wd][a[1:0]*8 +: 8]};
            default: rd = shadow[wd];
        endcase
        if (w) shadow[wd] = (shadow[wd] & ~bm) | wl;
        else last_rd = rd;

        @(posedge clk); #1;
        q.push_back(idle_e("R1"));
        e = idle_e("");
        e.adr = wd; e.dout = wl;
        if (w) begin
            for (int i = 0; i < WS; i++) begin
                e.cs_n = ~msk; e.tg = {"R6/", mtag}; q.push_back(e);
            end
            for (int i = 0; i < WP; i++) begin
                e.we_n = ~msk; e.doe = (i >= WH); e.tg = {"R7/", mtag}; q.push_back(e);
            end
            for (int i = 0; i < WRC; i++) begin
                e.cs_n = 4'hF; e.we_n = 4'hF; e.doe = 1'b1; e.tg = {"R6/", mtag}; q.push_back(e);
            end
        end else begin
            for (int i = 0; i < RA; i++) begin
                e.cs_n = ~msk; e.oe_n = 1'b0; e.tg = {"R8/", mtag}; q.push_back(e);
            end
            for (int i = 0; i < RT; i++) q.push_back(idle_e("R9"));
        end
        e = idle_e({"R10/", mtag});
        e.ack = 1'b1; e.chk_rd = 1'b1; e.rdat = last_rd;
        q.push_back(e);

        req = 1'b1; wr = w; mode = md; addr = a; wdata = d;
        @(posedge clk); #1;
        req = 1'b0; addr = ~a; wdata = ~d; mode = ~md;
        if (glitch) begin
            @(posedge clk); #1;
            req = 1'b1; wr = ~w; addr = a + 5;     // R11: request during a busy phase
            @(posedge clk); #1;
            req = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]    = (32'(i) * 32'h01030507) ^ 32'hA5C3_0F96;
            shadow[i] = (32'(i) * 32'h01030507) ^ 32'hA5C3_0F96;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        // R2: full-word read, write, readback
        xfer(0, 2'b00, UAW'(5), 32'h0, 0, "R2");
        xfer(1, 2'b00, UAW'(5), 32'hDEAD_BEEF, 0, "R2");
        xfer(0, 2'b00, UAW'(5), 32'h0, 0, "R2");
        // R3: half-word on both halves, then full-word view (R12)
        xfer(1, 2'b01, {UAW'(9), 1'b1}, 32'hFFFF_1234, 0, "R3");
        xfer(0, 2'b01, {UAW'(9), 1'b1}, 32'h0, 0, "R3");
        xfer(0, 2'b01, {UAW'(9), 1'b0}, 32'h0, 0, "R3");
        xfer(1, 2'b01, {UAW'(10), 1'b0}, 32'h0000_5AA5, 0, "R3");
        xfer(0, 2'b00, UAW'(9), 32'h0, 0, "R12");
        xfer(0, 2'b00, UAW'(10), 32'h0, 0, "R12");
        // R4: every byte lane of one word
        for (int l = 0; l < 4; l++)
            xfer(1, 2'b10, UAW'(12*4 + l), 32'hFFFF_FF10 + 32'(l), 0, "R4");
        for (int l = 3; l >= 0; l--)
            xfer(0, 2'b10, UAW'(12*4 + l), 32'h0, 0, "R4");
        xfer(1, 2'b10, UAW'(13*4 + 2), 32'h0000_00C7, 0, "R4");
        xfer(0, 2'b00, UAW'(13), 32'h0, 0, "R12");
        // R5: reserved mode acts as full word
        xfer(1, 2'b11, UAW'(20), 32'h0BAD_F00D, 0, "R5");
        xfer(0, 2'b11, UAW'(20), 32'h0, 0, "R5");
        // R11: requests while busy are dropped
        xfer(0, 2'b00, UAW'(20), 32'h0, 1, "R11");
        xfer(1, 2'b00, UAW'(21), 32'h1357_9BDF, 1, "R11");
        xfer(0, 2'b00, UAW'(21), 32'h0, 0, "R11");
        xfer(0, 2'b00, UAW'(26), 32'h0, 0, "R11");
        // top word in each width
        xfer(1, 2'b10, {UAW{1'b1}}, 32'h0000_0042, 0, "R4");
        xfer(0, 2'b01, {1'b0, {(UAW-1){1'b1}}}, 32'h0, 0, "R3");
        xfer(0, 2'b00, UAW'(DEPTH - 1), 32'h0, 0, "R2");
        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule